// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind a MAC receive path and moves each received frame into system memory. Memory holds a ring of two-word descriptors. The first word of a descriptor carries a word-aligned buffer address with two control bits in its low bits: an ownership flag and a wrap marker. The second word is filled in by the block with the frame length and the address-match class of the frame. The block reaches descriptors and buffers through a single word-wide memory master port that carries one request at a time.

Frame words enter through a small FIFO, so the MAC never has to stall. A state machine takes one frame at a time through these states:
- IDLE: waits for a queued word, then goes to FETCH.
- FETCH: reads the first descriptor word. If the ownership flag is clear it goes to DATA. If the flag is set it goes to DROP.
- DATA: stores the words, then goes to STAT after the last word. An overrun marker sends it back to IDLE.
- STAT: writes the length and flags word, then goes to OWN.
- OWN: writes the first word back with ownership set, advances the ring pointer, then returns to IDLE.
- DROP: discards the frame up to its last word, then returns to IDLE.

Three sticky status flags report frames received, buffers not available and overruns. Software loads the queue base pointer before it enables reception and returns each buffer by clearing its ownership bit.

Top module: `rxring_writer`

## Requirements
- R1: After reset the status flags, the queue base pointer and the current descriptor pointer are zero and no memory request is raised.
- R2: A write through `base_we` loads both the queue base pointer and the current descriptor pointer with `base_wdata`.
- R3: For each frame the block reads the first descriptor word at the current pointer. If its bit 0 is 0, the k-th frame word is written in arrival order to (word & ~3) + 4*k.
- R4: The second descriptor word, at pointer + 4, receives the byte length in bits [10:0] and `in_flags[8:0]` in bits [31:23]; all other bits are 0. The length is 4 per word, except the last word, which counts `in_lastb` bytes (0 meaning 4).
- R5: After the second word, the first descriptor word is rewritten with bit 0 set and bits [31:1] unchanged. The ownership write is the final write of the frame.
- R6: After the ownership write the current pointer moves on by 8. If bit 1 (wrap) of the descriptor was set, it goes back to the queue base pointer instead. Status bit 0 (frame received) is set.
- R7: If the fetched first word has bit 0 set, the frame is discarded with no memory write, status bit 1 (buffer not available) is set and the current pointer does not change.
- R8: A word that arrives while the FIFO is full is lost and status bit 2 (overrun) is set. The frame is abandoned without a length or ownership write, the pointer does not move, and the next frame uses the same descriptor.
- R9: Each status flag stays set until a one is written to its bit of `stat_clr`. A clear bit of `stat_clr` leaves its flag alone.
- R10: Frame words beyond `BUF_BYTES` are not written, and the length field counts only the bytes stored.
- R11: A memory request keeps its address, direction and write data stable until `mem_ack`.
- R12: While `rx_en` is low, incoming words are ignored: there is no memory access, no flag change and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Reception enable |
| in_valid | input | 1 | Frame word valid |
| in_data | input | 32 | Frame word |
| in_last | input | 1 | Last word of frame |
| in_lastb | input | 2 | Valid bytes in last word, 0 means 4 |
| in_flags | input | 9 | Address-match class flags, valid with last word |
| base_we | input | 1 | Load queue base pointer |
| base_wdata | input | 32 | Queue base pointer value |
| stat_clr | input | 3 | Write-one-to-clear for status flags |
| qbase_o | output | 32 | Queue base pointer |
| cur_desc_o | output | 32 | Current descriptor address |
| rx_stat_o | output | 3 | Status: bit0 received, bit1 no buffer, bit2 overrun |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest case to reach is an overrun, because a word is lost only when the FIFO is full. The bench enlarges the FIFO so that normal frames never fill it. For the overrun test it slows its memory model to several wait cycles per access and streams a frame much longer than the FIFO. It then checks that the descriptor was neither completed nor handed over, and that a following frame reuses the same descriptor.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    typedef struct packed {
        logic        err;
        logic        last;
        logic [1:0]  lastb;
        logic [8:0]  flags;
        logic [31:0] data;
    } rx_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DATA,
        ST_STAT,
        ST_OWN,
        ST_DROP
    } wr_state_t;

    localparam int STAT_REC = 0;
    localparam int STAT_BNA = 1;
    localparam int STAT_OVR = 2;

endpackage

// File: rtl/rxring_fifo.sv
module rxring_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] store [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) store[wp_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= step(wp_q);
            if (do_pop)  rp_q <= step(rp_q);
            cnt_q <= cnt_q + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
        end
    end

    assign dout  = store[rp_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (AW+1)'(DEPTH));
endmodule

// File: rtl/rxring_ingress.sv
module rxring_ingress
    import rxring_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic        in_last,
    input  logic [1:0]  in_lastb,
    input  logic [8:0]  in_flags,
    input  logic        fifo_full,
    output logic        push,
    output rx_word_t    push_word,
    output logic        ovr_evt
);
    logic skip_q, term_q;
    logic accept, lose, push_term;

    assign accept    = rx_en && in_valid && !fifo_full && !skip_q && !term_q;
    assign lose      = rx_en && in_valid && !accept;
    assign push_term = term_q && !fifo_full;
    assign push      = accept || push_term;
    assign ovr_evt   = lose;

    always_comb begin
        push_word = '0;
        if (push_term) begin
            push_word.err  = 1'b1;
            push_word.last = 1'b1;
        end else begin
            push_word.last  = in_last;
            push_word.lastb = in_lastb;
            push_word.flags = in_flags;
            push_word.data  = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
            term_q <= 1'b0;
        end else begin
            if (lose) skip_q <= !in_last;
            if (lose && !skip_q && !term_q) term_q <= 1'b1;
            else if (push_term)             term_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
    import rxring_pkg::*;
#(
    parameter int BUF_BYTES  = 1536,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic        in_last,
    input  logic [1:0]  in_lastb,
    input  logic [8:0]  in_flags,
    input  logic        base_we,
    input  logic [31:0] base_wdata,
    input  logic [2:0]  stat_clr,
    output logic [31:0] qbase_o,
    output logic [31:0] cur_desc_o,
    output logic [2:0]  rx_stat_o,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int OFF_W     = $clog2(BUF_WORDS) + 1;
    localparam int LEN_W     = 11;
    localparam int ENT_W     = $bits(rx_word_t);

    wr_state_t        state_q, state_d;
    logic [31:0]      qbase_q, cur_q;
    logic [31:1]      bufa_q;
    logic [OFF_W-1:0] woff_q;
    logic [LEN_W-1:0] len_q;
    logic [8:0]       flags_q;
    logic [2:0]       stat_q;

    logic             push, pop, ovr_evt, empty, full;
    rx_word_t         push_word, head;
    logic [ENT_W-1:0] head_raw;
    logic             room;
    logic [2:0]       head_bytes;

    rxring_ingress u_ingress (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_lastb(in_lastb),
        .in_flags(in_flags), .fifo_full(full), .push(push),
        .push_word(push_word), .ovr_evt(ovr_evt)
    );

    rxring_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_word),
        .pop(pop), .dout(head_raw), .empty(empty), .full(full)
    );

    assign head       = rx_word_t'(head_raw);
    assign room       = (woff_q < OFF_W'(BUF_WORDS));
    assign head_bytes = (head.last && head.lastb != 2'd0) ? {1'b0, head.lastb} : 3'd4;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!empty) state_d = ST_FETCH;
            ST_FETCH: if (mem_ack) state_d = mem_rdata[0] ? ST_DROP : ST_DATA;
            ST_DATA:  if (!empty) begin
                          if (head.err)              state_d = ST_IDLE;
                          else if (pop && head.last) state_d = ST_STAT;
                      end
            ST_STAT:  if (mem_ack) state_d = ST_OWN;
            ST_OWN:   if (mem_ack) state_d = ST_IDLE;
            ST_DROP:  if (!empty && head.last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pop       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q;
            end
            ST_DATA: if (!empty) begin
                if (head.err) begin
                    pop = 1'b1;
                end else if (room) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = {bufa_q[31:2], 2'b00} + (32'(woff_q) << 2);
                    mem_wdata = head.data;
                    pop       = mem_ack;
                end else begin
                    pop = 1'b1;
                end
            end
            ST_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + 32'd4;
                mem_wdata = {flags_q, 12'b0, len_q};
            end
            ST_OWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = {bufa_q, 1'b1};
            end
            ST_DROP: pop = !empty;
            default: ;
        endcase
    end

    // datapath and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qbase_q <= '0;
            cur_q   <= '0;
            bufa_q  <= '0;
            woff_q  <= '0;
            len_q   <= '0;
            flags_q <= '0;
            stat_q  <= '0;
        end else begin
            if (state_q == ST_FETCH && mem_ack && !mem_rdata[0]) begin
                bufa_q <= mem_rdata[31:1];
                woff_q <= '0;
                len_q  <= '0;
            end
            if (state_q == ST_DATA && pop && !head.err) begin
                if (room) begin
                    woff_q <= woff_q + 1'b1;
                    len_q  <= len_q + LEN_W'(head_bytes);
                end
                if (head.last) flags_q <= head.flags;
            end
            if (state_q == ST_OWN && mem_ack)
                cur_q <= bufa_q[1] ? qbase_q : cur_q + 32'd8;
            if (base_we) begin
                qbase_q <= base_wdata;
                cur_q   <= base_wdata;
            end
            stat_q <= (stat_q & ~stat_clr)
                    | {ovr_evt,
                       (state_q == ST_FETCH && mem_ack && mem_rdata[0]),
                       (state_q == ST_OWN && mem_ack)};
        end
    end

    assign qbase_o    = qbase_q;
    assign cur_desc_o = cur_q;
    assign rx_stat_o  = stat_q;
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk
    import rxring_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [31:0] mem_rdata,
    input logic        base_we,
    input logic [2:0]  stat_clr,
    input logic [2:0]  rx_stat_o,
    input logic [31:0] cur_desc_o,
    input logic [31:0] qbase_o,
    input wr_state_t   state_q
);
    // R11: request held stable until acknowledged
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !base_we)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R5: ownership write only follows the length/flags write
    p_own_after_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && $past(state_q) != ST_OWN) |-> ($past(state_q) == ST_STAT));

    // R7: buffer filling only starts on a descriptor with owner bit clear
    p_no_fill_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) == ST_FETCH) |-> !$past(mem_rdata[0]));

    // R6: pointer steps by 8 or returns to base
    p_cur_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_desc_o) && !$past(base_we))
        |-> (cur_desc_o == qbase_o || cur_desc_o == $past(cur_desc_o) + 32'd8));

    // R9: sticky flags
    p_sticky_rec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stat_o[STAT_REC] && !stat_clr[STAT_REC]) |=> rx_stat_o[STAT_REC]);
    p_sticky_bna_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stat_o[STAT_BNA] && !stat_clr[STAT_BNA]) |=> rx_stat_o[STAT_BNA]);
    p_sticky_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stat_o[STAT_OVR] && !stat_clr[STAT_OVR]) |=> rx_stat_o[STAT_OVR]);
endmodule

bind rxring_writer rxring_chk chk_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .base_we(base_we), .stat_clr(stat_clr),
    .rx_stat_o(rx_stat_o), .cur_desc_o(cur_desc_o), .qbase_o(qbase_o),
    .state_q(state_q)
);

// File: tb/rxring_writer_tb_top.sv
module rxring_writer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic [1:0]  in_lastb = '0;
    logic [8:0]  in_flags = '0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic [2:0]  stat_clr = '0;
    logic [31:0] qbase_o, cur_desc_o;
    logic [2:0]  rx_stat_o;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    rxring_writer #(.BUF_BYTES(32), .FIFO_DEPTH(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_lastb(in_lastb),
        .in_flags(in_flags), .base_we(base_we), .base_wdata(base_wdata),
        .stat_clr(stat_clr), .qbase_o(qbase_o), .cur_desc_o(cur_desc_o),
        .rx_stat_o(rx_stat_o), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // memory model
    logic [31:0] mem [0:1023];
    logic [31:0] wlog [0:1023];
    int          nwr = 0;
    int          lat = 0;
    int          cnt = 0;
    bit          pend = 0;
    bit          hold_bad = 0;
    logic [31:0] req_addr_q = '0;
    logic        bw_en = 1'b0;
    logic [9:0]  bw_idx = '0;
    logic [31:0] bw_dat = '0;

    always @(posedge clk) begin
        if (bw_en) mem[bw_idx] = bw_dat;
        if (mem_req && !mem_ack) begin
            if (pend && mem_addr != req_addr_q) hold_bad = 1;
            pend = 1;
            req_addr_q = mem_addr;
            if (cnt >= lat) begin
                cnt = 0;
                pend = 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[11:2]] = mem_wdata;
                    if (nwr < 1024) wlog[nwr] = mem_addr;
                    nwr++;
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                end
            end else begin
                cnt++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] val);
        @(negedge clk);
        bw_en = 1'b1; bw_idx = 10'(idx); bw_dat = val;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic clr(input logic [2:0] bits);
        @(negedge clk);
        stat_clr = bits;
        @(negedge clk);
        stat_clr = '0;
    endtask

    task automatic send(input int nw, input logic [1:0] lb,
                        input logic [8:0] fl, input logic [31:0] seed);
        for (int k = 0; k < nw; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seed + 32'(k);
            in_last  = (k == nw - 1);
            in_lastb = lb;
            in_flags = fl;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // descriptor i at 0x100+8i (word index 0x40+2i), buffer at 0x200+0x40i
    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1", "stat in reset", 32'(rx_stat_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "stat", 32'(rx_stat_o), 32'h0);
        chk("R1", "qbase", qbase_o, 32'h0);
        chk("R1", "cur", cur_desc_o, 32'h0);
        chk("R1", "mem_req", 32'(mem_req), 32'h0);
    endtask

    task automatic t_base;
        for (int i = 0; i < 3; i++) begin
            poke(32'h40 + 2*i, 32'h200 + 32'h40*i + ((i == 2) ? 32'h2 : 32'h0));
            poke(32'h41 + 2*i, 32'h0);
        end
        poke(32'h88, 32'hDEADBEEF);
        @(negedge clk);
        base_we = 1'b1; base_wdata = 32'h100;
        @(negedge clk);
        base_we = 1'b0;
        chk("R2", "qbase", qbase_o, 32'h100);
        chk("R2", "cur", cur_desc_o, 32'h100);
        rx_en = 1'b1;
    endtask

    task automatic t_basic_frame;
        int n0;
        n0 = nwr;
        send(5, 2'd2, 9'h101, 32'hA000_0000);
        settle(60);
        for (int k = 0; k < 5; k++)
            chk("R3", "data word", mem[32'h80 + k], 32'hA000_0000 + 32'(k));
        chk("R4", "len/flags", mem[32'h41], (32'h101 << 23) | 32'd18);
        chk("R5", "owner set", mem[32'h40], 32'h201);
        chk("R5", "write count", 32'(nwr - n0), 32'd7);
        chk("R5", "stat before own", wlog[nwr-2], 32'h104);
        chk("R5", "own is last", wlog[nwr-1], 32'h100);
        chk("R6", "advance", cur_desc_o, 32'h108);
        chk("R6", "rec flag", 32'(rx_stat_o), 32'h1);
    endtask

    task automatic t_clear;
        clr(3'b010);
        chk("R9", "other bit kept", 32'(rx_stat_o), 32'h1);
        clr(3'b001);
        chk("R9", "cleared", 32'(rx_stat_o), 32'h0);
    endtask

    task automatic t_wrap;
        send(3, 2'd0, 9'h000, 32'hB000_0000);
        settle(60);
        chk("R4", "full-word len", mem[32'h43], 32'd12);
        chk("R6", "step", cur_desc_o, 32'h110);
        send(2, 2'd1, 9'h1FF, 32'hC000_0000);
        settle(60);
        chk("R4", "flags all", mem[32'h45], 32'hFF80_0005);
        chk("R5", "wrap kept", mem[32'h44], 32'h283);
        chk("R6", "wrap to base", cur_desc_o, 32'h100);
    endtask

    task automatic t_owned;
        int n0;
        clr(3'b111);
        n0 = nwr;
        send(3, 2'd0, 9'h0, 32'hD000_0000);
        settle(60);
        chk("R7", "bna", 32'(rx_stat_o), 32'h2);
        chk("R7", "no writes", 32'(nwr - n0), 32'd0);
        chk("R7", "cur kept", cur_desc_o, 32'h100);
        chk("R7", "buffer kept", mem[32'h80], 32'hA000_0000);
    endtask

    task automatic t_limit;
        clr(3'b111);
        poke(32'h40, 32'h200);
        send(12, 2'd0, 9'h0, 32'hE000_0000);
        settle(80);
        chk("R10", "last stored", mem[32'h87], 32'hE000_0007);
        chk("R10", "beyond buffer", mem[32'h88], 32'hDEADBEEF);
        chk("R10", "len capped", mem[32'h41], 32'd32);
        chk("R10", "no overrun", 32'(rx_stat_o), 32'h1);
    endtask

    task automatic t_overrun;
        clr(3'b111);
        poke(32'h42, 32'h240);
        poke(32'h43, 32'h0);
        poke(32'h44, 32'h282);
        lat = 8;
        send(40, 2'd0, 9'h0, 32'hF000_0000);
        settle(400);
        chk("R8", "ovr flag", 32'(rx_stat_o), 32'h4);
        chk("R8", "cur kept", cur_desc_o, 32'h108);
        chk("R8", "not handed over", mem[32'h42], 32'h240);
        chk("R8", "no length", mem[32'h43], 32'h0);
        lat = 0;
        clr(3'b111);
        send(4, 2'd0, 9'h0, 32'h1200_0000);
        settle(60);
        chk("R8", "reuse owner", mem[32'h42], 32'h241);
        chk("R8", "reuse len", mem[32'h43], 32'd16);
        chk("R8", "reuse data", mem[32'h90], 32'h1200_0000);
        chk("R8", "reuse advance", cur_desc_o, 32'h110);
    endtask

    task automatic t_disabled;
        int n0;
        logic [31:0] c0;
        clr(3'b111);
        rx_en = 1'b0;
        n0 = nwr;
        c0 = cur_desc_o;
        send(3, 2'd0, 9'h0, 32'h3300_0000);
        settle(40);
        chk("R12", "no writes", 32'(nwr - n0), 32'd0);
        chk("R12", "no flags", 32'(rx_stat_o), 32'h0);
        chk("R12", "cur kept", cur_desc_o, c0);
        rx_en = 1'b1;
    endtask

    initial begin
        t_reset();
        t_base();
        t_basic_frame();
        t_clear();
        t_wrap();
        t_owned();
        t_limit();
        t_overrun();
        t_disabled();
        chk("R11", "request stability", 32'(hold_bad), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule